// File: doc/BRIEF.md
# Table-Driven Digit-Serial Binary Field Multiplier

This block multiplies two elements of a binary extension field held in polynomial basis. Two fields are built in: one of degree 233 with reduction trinomial x^233 + x^74 + 1, and one of degree 409 with x^409 + x^87 + 1. A field-select input picks between them for each operation. The datapath is 409 bits wide in both cases. With the smaller field selected, every bit at position 233 and above is forced to zero.

A start strobe captures both operands and the field choice. The block first spends three cycles building a 16-entry table. Entry u holds operand A times the 4-bit polynomial whose coefficients are the bits of u, reduced in the selected field. It then walks operand B four bits at a time, most significant digit first. Each cycle it multiplies the running sum by x^4, folds the overflow back with the trinomial, and XORs in the table entry addressed by the current digit. When the last digit has been absorbed, the product appears on the output together with a one-cycle done pulse. The product holds until the next accepted start.

Top module: `gf_lut_mult`

## Requirements
- R1: With fsel=0, prod equals op_a times op_b reduced modulo x^233 + x^74 + 1.
- R2: With fsel=1, prod equals op_a times op_b reduced modulo x^409 + x^87 + 1.
- R3: fsel is sampled only on an accepted start. With fsel=0, operand bits 233..408 have no effect and prod bits 233..408 are zero.
- R4: The table is rebuilt in the three cycles after each accepted start. The digits of B are then consumed one per cycle, most significant first: 59 digits for degree 233 (top digit zero-padded) and 103 for degree 409. done is high after the clock edge that comes 62 (fsel=0) or 106 (fsel=1) edges after the edge that samples start.
- R5: done is high for exactly one cycle per operation.
- R6: While idle, prod stays unchanged until a start is accepted.
- R7: A start seen while an operation is running is ignored, including in the cycle in which the last digit is absorbed. The operands, field and latency of the running operation are unchanged, and no further done follows.
- R8: A start presented in the cycle in which done is high is accepted and begins a new operation.
- R9: After reset, done is 0 and prod is all zeros.
- R10: Multiplying by the zero polynomial gives zero, and multiplying by the constant 1 returns the other operand reduced to the selected field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only while idle |
| fsel | input | 1 | Field choice: 0 = degree 233, 1 = degree 409 |
| op_a | input | 409 | Multiplicand, used to build the table |
| op_b | input | 409 | Multiplier, consumed four bits per cycle |
| prod | output | 409 | Product, valid while done is high and held afterwards |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
Two events can meet in one cycle: a new start request and the completion of the running product. The bench raises start with different operands and the other field in the exact cycle the last digit is absorbed. It must see the original product with the original latency, and no second done in the following 150 cycles. It then raises start in the cycle done is high. It must see the first product intact and a second, correct product after a full latency. Every product is compared with a bit-serial shift-and-add reference that reduces by the trinomial one bit at a time.

// File: rtl/gf_lut_pkg.sv
package gf_lut_pkg;
  parameter int W     = 409;   // datapath width (largest field degree)
  parameter int M_LO  = 233;   // degree of the small field
  parameter int K_LO  = 74;    // middle term of the small trinomial
  parameter int K_HI  = 87;    // middle term of the large trinomial
  parameter int DIG   = 4;     // digit width of operand B
  localparam int NTBL  = 1 << DIG;
  localparam int ND_LO = (M_LO + DIG - 1) / DIG;
  localparam int ND_HI = (W + DIG - 1) / DIG;
  localparam int IDX_W = $clog2(ND_HI);
  localparam int BPAD  = ND_HI * DIG;
  localparam int BW    = $clog2(BPAD);

  typedef logic [W-1:0] word_t;
  typedef enum logic [2:0] {S_IDLE, S_F1, S_F2, S_F3, S_RUN} st_t;

  // keeps the coefficients that exist in the selected field
  function automatic word_t fmask(input logic hi);
    word_t m;
    m = '0;
    m[M_LO-1:0] = '1;
    return hi ? '1 : m;
  endfunction

  // v * x, folded once by the selected trinomial
  function automatic word_t mul_x(input word_t v, input logic hi);
    word_t r;
    logic  ov;
    ov = hi ? v[W-1] : v[M_LO-1];
    r  = (v << 1) & fmask(hi);
    r[0] = r[0] ^ ov;
    if (hi) r[K_HI] = r[K_HI] ^ ov;
    else    r[K_LO] = r[K_LO] ^ ov;
    return r;
  endfunction

  // v * x^DIG, single fold valid because DIG < m - k in both fields
  function automatic word_t mul_xd(input word_t v, input logic hi);
    word_t          r;
    logic [DIG-1:0] ov;
    ov = hi ? v[W-1 -: DIG] : v[M_LO-1 -: DIG];
    r  = (v << DIG) & fmask(hi);
    r[DIG-1:0] = r[DIG-1:0] ^ ov;
    if (hi) r[K_HI +: DIG] = r[K_HI +: DIG] ^ ov;
    else    r[K_LO +: DIG] = r[K_LO +: DIG] ^ ov;
    return r;
  endfunction
endpackage

// File: rtl/gf_lut_ctrl.sv
module gf_lut_ctrl
  import gf_lut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sel_q,
  output logic             accept,
  output logic             ph1,
  output logic             ph2,
  output logic             ph3,
  output logic             run,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  st_t st;

  assign accept = start && (st == S_IDLE);
  assign ph1    = (st == S_F1);
  assign ph2    = (st == S_F2);
  assign ph3    = (st == S_F3);
  assign run    = (st == S_RUN);
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) st <= S_F1;
        S_F1:   st <= S_F2;
        S_F2:   st <= S_F3;
        S_F3: begin
          st  <= S_RUN;
          idx <= sel_q ? IDX_W'(ND_HI - 1) : IDX_W'(ND_LO - 1);
        end
        S_RUN: begin
          if (idx == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  fill_seq_a_chk: assert property (@(posedge clk) disable iff (!rst_n) ph1 |=> ph2);
  // R4
  fill_seq_b_chk: assert property (@(posedge clk) disable iff (!rst_n) ph2 |=> ph3);
  // R4
  fill_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n) ph3 |=> run);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_restart_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && start) |=> ph1);
endmodule

// File: rtl/gf_lut_table.sv
module gf_lut_table
  import gf_lut_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ph1,
  input  logic           ph2,
  input  logic           ph3,
  input  logic           sel,
  input  word_t          a_q,
  input  logic [DIG-1:0] rd_sel,
  output word_t          rd_word
);
  word_t ax1, ax2, ax3;
  word_t basis [DIG];
  word_t comb  [NTBL];
  word_t tbl   [NTBL];

  assign basis[0] = a_q;
  assign basis[1] = ax1;
  assign basis[2] = ax2;
  assign basis[3] = ax3;

  // entry u = XOR of A*x^j over the set bits j of u
  genvar gu;
  generate
    for (gu = 0; gu < NTBL; gu++) begin : g_comb
      always_comb begin
        comb[gu] = '0;
        for (int j = 0; j < DIG; j++)
          if (((gu >> j) & 1) != 0) comb[gu] = comb[gu] ^ basis[j];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ax1 <= '0;
      ax2 <= '0;
      ax3 <= '0;
      for (int u = 0; u < NTBL; u++) tbl[u] <= '0;
    end else begin
      if (ph1) ax1 <= mul_x(a_q, sel);
      if (ph2) begin
        ax2 <= mul_x(ax1, sel);
        ax3 <= mul_x(mul_x(ax1, sel), sel);
      end
      if (ph3) for (int u = 0; u < NTBL; u++) tbl[u] <= comb[u];
    end
  end

  assign rd_word = tbl[rd_sel];

  // R1
  tbl_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph3 |=> (tbl[1] == $past(a_q)));
  // R3
  tbl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph3 && !sel) |=> (tbl[NTBL-1][W-1:M_LO] == '0));
endmodule

// File: rtl/gf_lut_acc.sv
module gf_lut_acc
  import gf_lut_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  en,
  input  logic  sel,
  input  word_t word_in,
  output word_t acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= mul_xd(acc, sel) ^ word_in;
  end

  // R3
  acc_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sel) |=> (acc[W-1:M_LO] == '0));
endmodule

// File: rtl/gf_lut_mult.sv
module gf_lut_mult
  import gf_lut_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         fsel,
  input  logic [408:0] op_a,
  input  logic [408:0] op_b,
  output logic [408:0] prod,
  output logic         done
);
  logic             accept, ph1, ph2, ph3, run, busy, sel_q;
  logic [IDX_W-1:0] idx;
  word_t            a_q, rd_word, acc;
  logic [BPAD-1:0]  b_q;
  logic [BW-1:0]    dig_base;
  logic [DIG-1:0]   digit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      sel_q <= 1'b0;
    end else if (accept) begin
      a_q   <= op_a & fmask(fsel);
      b_q   <= {{(BPAD-W){1'b0}}, op_b & fmask(fsel)};
      sel_q <= fsel;
    end
  end

  assign dig_base = BW'(idx) * BW'(DIG);
  assign digit    = b_q[dig_base +: DIG];

  gf_lut_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_q(sel_q),
    .accept(accept), .ph1(ph1), .ph2(ph2), .ph3(ph3), .run(run),
    .busy(busy), .idx(idx), .done(done)
  );

  gf_lut_table table_i (
    .clk(clk), .rst_n(rst_n), .ph1(ph1), .ph2(ph2), .ph3(ph3),
    .sel(sel_q), .a_q(a_q), .rd_sel(digit), .rd_word(rd_word)
  );

  gf_lut_acc acc_i (
    .clk(clk), .rst_n(rst_n), .clr(ph3), .en(run), .sel(sel_q),
    .word_in(rd_word), .acc(acc)
  );

  assign prod = acc;

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(prod));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(a_q) && $stable(b_q) && $stable(sel_q)));
endmodule

// File: tb/gf_lut_mult_tb_top.sv
`timescale 1ns/1ps
module gf_lut_mult_tb_top;
  typedef logic [408:0] wd_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic fsel = 1'b0;
  wd_t  op_a = '0;
  wd_t  op_b = '0;
  wd_t  prod;
  logic done;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 0;

  always #2 clk = ~clk;

  gf_lut_mult dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fsel(fsel),
    .op_a(op_a), .op_b(op_b), .prod(prod), .done(done)
  );

  function automatic wd_t fld_mask(input bit hi);
    wd_t one = 1;
    return (one << (hi ? 409 : 233)) - 1;
  endfunction

  // bit-serial shift-and-add, reducing one bit per step
  function automatic wd_t ref_mul(input wd_t a, input wd_t b, input bit hi);
    int  m = hi ? 409 : 233;
    int  k = hi ? 87 : 74;
    wd_t mk = fld_mask(hi);
    wd_t r = '0;
    bit  t;
    for (int i = m - 1; i >= 0; i--) begin
      t = r[m-1];
      r = (r << 1) & mk;
      if (t) begin r[0] = ~r[0]; r[k] = ~r[k]; end
      if (b[i]) r = r ^ (a & mk);
    end
    return r;
  endfunction

  function automatic wd_t rnd_word();
    wd_t r = '0;
    for (int i = 0; i < 13; i++) r = (r << 32) | wd_t'($urandom);
    return r;
  endfunction

  task automatic chk_w(input string req, input wd_t act, input wd_t exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_i(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input bit hi);
    return hi ? 106 : 62;
  endfunction

  // waits for done after the sampling edge; counts further edges
  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 400) begin
      @(posedge clk); lat++; @(negedge clk);
    end
  endtask

  task automatic do_mul(input wd_t a, input wd_t b, input bit hi,
                        output wd_t got, output int lat);
    @(negedge clk);
    op_a = a; op_b = b; fsel = hi; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    got = prod;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_i("R9 done after reset", int'(done), 0);
    chk_w("R9 prod after reset", prod, '0);
  endtask

  task automatic t_small_ops(input bit hi);
    wd_t a = rnd_word(), got;
    int  lat;
    string rq = hi ? "R2" : "R1";
    do_mul(a, '0, hi, got, lat);
    chk_w({"R10 a*0 ", rq}, got, '0);
    do_mul(a, wd_t'(1), hi, got, lat);
    chk_w({"R10 a*1 ", rq}, got, a & fld_mask(hi));
    do_mul(wd_t'(1), a, hi, got, lat);
    chk_w({"R10 1*b ", rq}, got, a & fld_mask(hi));
    do_mul('0, a, hi, got, lat);
    chk_w({"R10 0*b ", rq}, got, '0);
  endtask

  task automatic t_random(input bit hi, input int n);
    for (int i = 0; i < n; i++) begin
      wd_t a = rnd_word() & fld_mask(hi);
      wd_t b = rnd_word() & fld_mask(hi);
      wd_t got;
      int  lat;
      if (i == 0) begin a = fld_mask(hi); b = fld_mask(hi); end
      do_mul(a, b, hi, got, lat);
      chk_w(hi ? "R2 random product" : "R1 random product", got, ref_mul(a, b, hi));
      chk_i("R4 latency", lat, exp_lat(hi));
      @(negedge clk);
      chk_i("R5 done one cycle", int'(done), 0);
    end
  endtask

  task automatic t_upper_ignored();
    wd_t a = rnd_word() | ~fld_mask(1'b0);
    wd_t b = rnd_word() | ~fld_mask(1'b0);
    wd_t got;
    int  lat;
    do_mul(a, b, 1'b0, got, lat);
    chk_w("R3 upper operand bits ignored", got, ref_mul(a, b, 1'b0));
    chk_w("R3 upper result bits zero", got & ~fld_mask(1'b0), '0);
  endtask

  task automatic t_hold();
    wd_t a = rnd_word(), b = rnd_word(), got;
    int  lat;
    do_mul(a, b, 1'b1, got, lat);
    op_a = rnd_word(); op_b = rnd_word(); fsel = 1'b0;
    repeat (20) @(negedge clk);
    chk_w("R6 product held while idle", prod, ref_mul(a, b, 1'b1));
  endtask

  // start requests mid-run and in the last-digit cycle are ignored
  task automatic t_busy_start();
    wd_t a = rnd_word(), b = rnd_word(), got;
    int  lat = 0;
    bit  extra = 0;
    @(negedge clk);
    op_a = a; op_b = b; fsel = 1'b0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 400) begin
      if (lat == 30 || lat == exp_lat(1'b0) - 1) begin
        op_a = rnd_word(); op_b = rnd_word(); fsel = 1'b1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); lat++; @(negedge clk);
    end
    start = 1'b0;
    got = prod;
    chk_w("R7 busy start ignored product", got, ref_mul(a, b, 1'b0));
    chk_i("R7 busy start ignored latency", lat, exp_lat(1'b0));
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (done) extra = 1;
    end
    chk_i("R7 no extra done", int'(extra), 0);
    chk_w("R7 product unchanged after ignored start", prod, ref_mul(a, b, 1'b0));
  endtask

  // start raised in the done cycle begins a new operation
  task automatic t_done_start();
    wd_t a = rnd_word(), b = rnd_word();
    wd_t a2 = rnd_word(), b2 = rnd_word(), got;
    int  lat;
    do_mul(a, b, 1'b1, got, lat);
    chk_w("R8 first product", got, ref_mul(a, b, 1'b1));
    op_a = a2; op_b = b2; fsel = 1'b0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk_w("R8 restart in done cycle product", prod, ref_mul(a2, b2, 1'b0));
    chk_i("R8 restart latency", lat, exp_lat(1'b0));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_small_ops(1'b0);
    t_small_ops(1'b1);
    t_random(1'b0, 8);
    t_random(1'b1, 8);
    t_upper_ignored();
    t_hold();
    t_busy_start();
    t_done_start();
    finish_run();
  end
endmodule